// File: doc/BRIEF.md
# External Clock Bypass Controller

This block decides when the I/O clock tree should run from an external clock instead of its internal source. A bypass can be requested in two ways: by a hardware request line, or by software through a small register port. Both paths run the same request/acknowledge handshake with the clock source, but they differ in what happens once the source acknowledges. A hardware bypass returns an acknowledge to the requester and steps the dividers down unless scan mode is active. A software bypass never acknowledges the hardware requester, and it steps the dividers down only when the software has also chosen high speed.

The divided I/O clocks are modelled as clock-enable pulses in the single `clk_i` domain. At normal speed the divide-by-2 enable fires on every second cycle and the divide-by-4 enable on every fourth cycle. After step-down the divide-by-2 enable is high on every cycle and the divide-by-4 enable fires on every second cycle.

The controller is a six-state machine. IDLE waits for a request, and a hardware request takes priority. REQ_HW and REQ_SW drive the source request and wait for the acknowledge. BYP_HW and BYP_SW are the bypassed states. RELEASE drops the source request and holds the divider setting until the acknowledge goes low. The transitions are as follows:
- IDLE to REQ_HW on a hardware request.
- IDLE to REQ_SW when the software request is valid and no hardware request is present.
- REQ_x to BYP_x on the acknowledge.
- REQ_x or BYP_x to RELEASE when that path's request drops.
- RELEASE to IDLE once the acknowledge is low.

Top module: `clk_bypass_ctrl`

## Requirements
- R1: After reset the following hold: `src_req_o`, `hw_ack_o` and `step_down_o` are 0; the select and high-speed registers read 4'b1001; the lock register reads 1.
- R2: When the controller is idle, a high `hw_req_i` raises `src_req_o` one clock later.
- R3: A software bypass is requested, and `src_req_o` raised, only when the select register (address 0) holds 4'b0110 and `dbg_en_i` is high. The value 4'b1001 and any other value count as false.
- R4: A write to the select register is ignored unless the lock register (address 2) reads 1. Writes to the high-speed register (address 1) are never locked.
- R5: Writing 1 to bit 0 of the lock register clears it. It then stays 0 until reset.
- R6: When the source acknowledges a hardware request, `hw_ack_o` rises on the next clock. `step_down_o` goes to 1 at the same time, unless `scan_i` is high.
- R7: When the source acknowledges a software request, `hw_ack_o` stays 0. `step_down_o` is 1 only if the high-speed register (address 1) holds 4'b0110.
- R8: With `step_down_o` at 0, over any 8 cycles `div2_en_o` pulses 4 times and `div4_en_o` pulses 2 times. With `step_down_o` at 1, they pulse 8 and 4 times.
- R9: When the active request drops, `src_req_o` and `hw_ack_o` fall one clock later. `step_down_o` keeps its value while `src_ack_i` stays high, and clears one clock after `src_ack_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_req_i | input | 1 | Hardware bypass request |
| dbg_en_i | input | 1 | Debug enable, gates the software request |
| scan_i | input | 1 | Scan mode, defeats the hardware step-down |
| src_ack_i | input | 1 | Acknowledge from the clock source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 select, 1 high-speed, 2 lock) |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 4 | Read data for `reg_addr_i`, combinational |
| src_req_o | output | 1 | Bypass request to the clock source |
| hw_ack_o | output | 1 | Acknowledge to the hardware requester |
| step_down_o | output | 1 | Divider step-down control |
| div2_en_o | output | 1 | Divide-by-2 clock enable pulse |
| div4_en_o | output | 1 | Divide-by-4 clock enable pulse |

## Verification
A wrong state shows within one clock of the triggering input. An FSM stuck in a request state keeps `src_req_o` high after the request drops. A bypass recorded under the wrong path appears as a spurious `hw_ack_o`, or as a `step_down_o` that does not follow scan or the high-speed register. A corrupted hold register shows as `step_down_o` changing in RELEASE while the acknowledge is still high. Lock and encoding errors show at once on read-back, or as a source request that should not appear.

// File: rtl/clk_byp_pkg.sv
package clk_byp_pkg;
    parameter int unsigned MUBI_W = 4;
    parameter int unsigned ADDR_W = 2;

    localparam logic [MUBI_W-1:0] MUBI_TRUE  = 4'b0110;
    localparam logic [MUBI_W-1:0] MUBI_FALSE = 4'b1001;

    localparam logic [ADDR_W-1:0] ADDR_SEL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_HS   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_LOCK = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_HW,
        ST_REQ_SW,
        ST_BYP_HW,
        ST_BYP_SW,
        ST_RELEASE
    } byp_state_e;

    function automatic logic mubi_is_true(input logic [MUBI_W-1:0] v);
        return v == MUBI_TRUE;
    endfunction
endpackage

// File: rtl/clk_byp_regs.sv
module clk_byp_regs
    import clk_byp_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [MUBI_W-1:0] wdata_i,
    output logic [MUBI_W-1:0] rdata_o,
    output logic              sel_true_o,
    output logic              hs_true_o,
    output logic              lock_o
);
    logic [MUBI_W-1:0] sel_q;
    logic [MUBI_W-1:0] hs_q;
    logic              lock_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_q  <= MUBI_FALSE;
            hs_q   <= MUBI_FALSE;
            lock_q <= 1'b1;
        end else if (we_i) begin
            if (addr_i == ADDR_SEL && lock_q) begin
                sel_q <= wdata_i;
            end
            if (addr_i == ADDR_HS) begin
                hs_q <= wdata_i;
            end
            if (addr_i == ADDR_LOCK && wdata_i[0]) begin
                lock_q <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (addr_i)
            ADDR_SEL:  rdata_o = sel_q;
            ADDR_HS:   rdata_o = hs_q;
            ADDR_LOCK: rdata_o = {{(MUBI_W-1){1'b0}}, lock_q};
            default:   rdata_o = '0;
        endcase
    end

    assign sel_true_o = mubi_is_true(sel_q);
    assign hs_true_o  = mubi_is_true(hs_q);
    assign lock_o     = lock_q;
endmodule

// File: rtl/clk_byp_fsm.sv
module clk_byp_fsm
    import clk_byp_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       hw_req_i,
    input  logic       sw_req_i,
    input  logic       scan_i,
    input  logic       hs_true_i,
    input  logic       src_ack_i,
    output logic       src_req_o,
    output logic       hw_ack_o,
    output logic       step_down_o,
    output byp_state_e state_o
);
    byp_state_e state_q, state_d;
    logic       hold_q;
    logic       step_now;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hw_req_i)      state_d = ST_REQ_HW;
                else if (sw_req_i) state_d = ST_REQ_SW;
            end
            ST_REQ_HW: begin
                if (!hw_req_i)      state_d = ST_RELEASE;
                else if (src_ack_i) state_d = ST_BYP_HW;
            end
            ST_REQ_SW: begin
                if (!sw_req_i)      state_d = ST_RELEASE;
                else if (src_ack_i) state_d = ST_BYP_SW;
            end
            ST_BYP_HW: begin
                if (!hw_req_i) state_d = ST_RELEASE;
            end
            ST_BYP_SW: begin
                if (!sw_req_i) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (!src_ack_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        src_req_o = 1'b0;
        hw_ack_o  = 1'b0;
        step_now  = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_REQ_HW:  src_req_o = 1'b1;
            ST_REQ_SW:  src_req_o = 1'b1;
            ST_BYP_HW: begin
                src_req_o = 1'b1;
                hw_ack_o  = 1'b1;
                step_now  = !scan_i;
            end
            ST_BYP_SW: begin
                src_req_o = 1'b1;
                step_now  = hs_true_i;
            end
            ST_RELEASE: step_now = hold_q;
            default:    ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hold_q <= 1'b0;
        end else if (state_q == ST_BYP_HW || state_q == ST_BYP_SW) begin
            hold_q <= step_now;
        end else if (state_q == ST_IDLE) begin
            hold_q <= 1'b0;
        end
    end

    assign step_down_o = step_now;
    assign state_o     = state_q;
endmodule

// File: rtl/clk_byp_div.sv
module clk_byp_div #(
    parameter int unsigned CNT_W = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic step_down_i,
    output logic div2_en_o,
    output logic div4_en_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        if (step_down_i) begin
            div2_en_o = 1'b1;
            div4_en_o = cnt_q[0];
        end else begin
            div2_en_o = cnt_q[0];
            div4_en_o = (cnt_q[1:0] == CNT_MAX[1:0]);
        end
    end
endmodule

// File: rtl/clk_bypass_ctrl.sv
module clk_bypass_ctrl
    import clk_byp_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              hw_req_i,
    input  logic              dbg_en_i,
    input  logic              scan_i,
    input  logic              src_ack_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [MUBI_W-1:0] reg_wdata_i,
    output logic [MUBI_W-1:0] reg_rdata_o,
    output logic              src_req_o,
    output logic              hw_ack_o,
    output logic              step_down_o,
    output logic              div2_en_o,
    output logic              div4_en_o
);
    logic       sel_true;
    logic       hs_true;
    logic       lock;
    logic       sw_req;
    byp_state_e fsm_state;

    clk_byp_regs u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (reg_we_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .sel_true_o (sel_true),
        .hs_true_o  (hs_true),
        .lock_o     (lock)
    );

    assign sw_req = sel_true && dbg_en_i;

    clk_byp_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .hw_req_i    (hw_req_i),
        .sw_req_i    (sw_req),
        .scan_i      (scan_i),
        .hs_true_i   (hs_true),
        .src_ack_i   (src_ack_i),
        .src_req_o   (src_req_o),
        .hw_ack_o    (hw_ack_o),
        .step_down_o (step_down_o),
        .state_o     (fsm_state)
    );

    clk_byp_div #(.CNT_W(2)) u_div (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .step_down_i (step_down_o),
        .div2_en_o   (div2_en_o),
        .div4_en_o   (div4_en_o)
    );
endmodule

// File: rtl/clk_byp_chk.sv
module clk_byp_chk
    import clk_byp_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic       hw_req_i,
    input logic       dbg_en_i,
    input logic       scan_i,
    input logic       src_ack_i,
    input logic       src_req_o,
    input logic       hw_ack_o,
    input logic       step_down_o,
    input logic       div2_en_o,
    input logic       sel_true,
    input logic       hs_true,
    input logic       lock,
    input byp_state_e fsm_state
);
    // R2
    hw_req_raises_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_state == ST_IDLE && hw_req_i) |=> src_req_o);

    // R3
    sw_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_state == ST_IDLE && !hw_req_i && !(sel_true && dbg_en_i)) |=> !src_req_o);

    // R5
    lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock |=> !lock);

    // R6
    hw_ack_with_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hw_ack_o |-> src_req_o);

    // R6
    hw_step_scan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_state == ST_BYP_HW) |-> (step_down_o == !scan_i));

    // R7
    sw_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_state == ST_BYP_SW) |-> (!hw_ack_o && step_down_o == hs_true));

    // R8
    step_div2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_down_o |-> div2_en_o);

    // R9
    release_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(fsm_state) == ST_RELEASE && fsm_state == ST_RELEASE && $past(src_ack_i))
            |-> $stable(step_down_o));

    // R9
    release_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_state == ST_RELEASE) |-> (!src_req_o && !hw_ack_o));
endmodule

bind clk_bypass_ctrl clk_byp_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hw_req_i    (hw_req_i),
    .dbg_en_i    (dbg_en_i),
    .scan_i      (scan_i),
    .src_ack_i   (src_ack_i),
    .src_req_o   (src_req_o),
    .hw_ack_o    (hw_ack_o),
    .step_down_o (step_down_o),
    .div2_en_o   (div2_en_o),
    .sel_true    (sel_true),
    .hs_true     (hs_true),
    .lock        (lock),
    .fsm_state   (fsm_state)
);

// File: tb/clk_bypass_ctrl_tb.sv
module clk_bypass_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_req = 1'b0, dbg_en = 1'b0, scan = 1'b0, ack = 1'b0;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [3:0] wdata = 4'd0;
    logic [3:0] rdata;
    logic       src_req, hw_ack, step, d2, d4;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    clk_bypass_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw_req), .dbg_en_i(dbg_en),
        .scan_i(scan), .src_ack_i(ack), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .src_req_o(src_req),
        .hw_ack_o(hw_ack), .step_down_o(step), .div2_en_o(d2), .div4_en_o(d4)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        addr = a; wdata = d; we = 1'b1;
        tick();
        we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input int exp);
        addr = a;
        #0.5;
        check(req, int'(rdata), exp);
    endtask

    task automatic rate_check(input string req, input int e2, input int e4);
        int c2 = 0;
        int c4 = 0;
        for (int i = 0; i < 8; i++) begin
            c2 += int'(d2);
            c4 += int'(d4);
            tick();
        end
        check({req, " div2"}, c2, e2);
        check({req, " div4"}, c4, e4);
    endtask

    task automatic t_reset();
        check("R1 src_req", int'(src_req), 0);
        check("R1 hw_ack", int'(hw_ack), 0);
        check("R1 step", int'(step), 0);
        rd_check("R1 sel", 2'd0, 9);
        rd_check("R1 hs", 2'd1, 9);
        rd_check("R1 lock", 2'd2, 1);
        rate_check("R8 normal", 4, 2);
    endtask

    task automatic t_hw(input logic sc);
        scan = sc;
        hw_req = 1'b1;
        tick();
        check("R2 src_req", int'(src_req), 1);
        check("R2 hw_ack before ack", int'(hw_ack), 0);
        ack = 1'b1;
        tick();
        check("R6 hw_ack", int'(hw_ack), 1);
        check("R6 step", int'(step), sc ? 0 : 1);
        if (!sc) rate_check("R8 stepped", 8, 4);
        hw_req = 1'b0;
        tick();
        check("R9 src_req drop", int'(src_req), 0);
        check("R9 hw_ack drop", int'(hw_ack), 0);
        check("R9 step held", int'(step), sc ? 0 : 1);
        tick(2);
        check("R9 step held ack high", int'(step), sc ? 0 : 1);
        ack = 1'b0;
        tick();
        check("R9 step cleared", int'(step), 0);
        scan = 1'b0;
    endtask

    task automatic t_sw(input logic [3:0] hs);
        wr(2'd1, hs);
        dbg_en = 1'b1;
        wr(2'd0, 4'b0110);
        tick();
        check("R3 sw src_req", int'(src_req), 1);
        ack = 1'b1;
        tick();
        check("R7 hw_ack stays low", int'(hw_ack), 0);
        check("R7 step", int'(step), (hs == 4'b0110) ? 1 : 0);
        wr(2'd0, 4'b1001);
        tick();
        check("R9 sw src_req drop", int'(src_req), 0);
        ack = 1'b0;
        tick();
        check("R9 sw step cleared", int'(step), 0);
        dbg_en = 1'b0;
    endtask

    task automatic t_sw_blocked();
        wr(2'd0, 4'b0110);
        dbg_en = 1'b0;
        tick(3);
        check("R3 no dbg_en", int'(src_req), 0);
        wr(2'd0, 4'b0111);
        dbg_en = 1'b1;
        tick(3);
        check("R3 invalid encoding", int'(src_req), 0);
        rd_check("R3 readback", 2'd0, 7);
        wr(2'd0, 4'b1001);
        dbg_en = 1'b0;
        tick();
    endtask

    task automatic t_lock();
        wr(2'd2, 4'b0001);
        rd_check("R5 lock cleared", 2'd2, 0);
        wr(2'd0, 4'b0110);
        rd_check("R4 sel locked", 2'd0, 9);
        dbg_en = 1'b1;
        tick(3);
        check("R4 no sw req when locked", int'(src_req), 0);
        wr(2'd1, 4'b0110);
        rd_check("R4 hs writable", 2'd1, 6);
        wr(2'd2, 4'b0000);
        rd_check("R5 lock stays 0", 2'd2, 0);
        wr(2'd2, 4'b0001);
        rd_check("R5 lock stays 0 after w1", 2'd2, 0);
        dbg_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_hw(1'b0);
        t_hw(1'b1);
        t_sw(4'b0110);
        t_sw(4'b1001);
        t_sw_blocked();
        t_lock();
        finish_run();
    end
endmodule